// File: doc/BRIEF.md
# Pin-Counted Buffer Frame Manager

This block keeps a small pool of frames, each caching one page of a slow backing store. For every frame it tracks whether it holds a page, which page that is, how many requesters currently hold it pinned, and whether its contents were modified. Requesters send one command at a time. A pin command carries a page id. An unpin command carries a frame number and a flag that says whether the holder changed the frame.

On a pin whose page is already resident, the block raises that frame's pin count and answers at once with the frame number. On a pin whose page is absent, it takes the lowest-numbered frame with no pins. If that frame holds modified data, the block first has the store write it out. It then has the store read the wanted page into the frame, and answers with the frame, now pinned once. While a miss is in service, the request port reports not ready. If every frame is pinned, the pin completes at once with a busy status. The store is reached through a request/acknowledge pair. The data movement itself belongs to the store model.

Top module: `frame_pool_mgr`

## Requirements
- R1: After reset no frame holds a page, req_ready is 1, rsp_valid is 0 and st_req is 0.
- R2: A pin of a resident page whose pin count is below the maximum raises that count by one. It answers with status 0 (hit) and that frame's number, with rsp_valid high in the cycle after the request is accepted.
- R3: A pin of an absent page chooses the lowest-numbered frame whose pin count is zero. A pinned frame is never chosen.
- R4: If the chosen frame holds a page and is dirty, the block first issues a store request with st_write=1, that frame's old page and the frame number. Only after that request is acknowledged does it issue the read (st_write=0). A clean or empty frame gets the read only.
- R5: When the read is acknowledged, the frame holds the new page with pin count 1 and clean. The response carries status 1 (filled) and the frame number.
- R6: The dirty flag clears when the write-back is acknowledged, so a refilled frame needs no further write-back unless it is modified again.
- R7: A pin of an absent page when every frame is pinned answers with status 3 (busy). It makes no store request and changes no frame.
- R8: An unpin of a frame with a nonzero count lowers that count by one and answers with status 2 (done). When its modified flag is 1, it also marks the frame dirty.
- R9: An unpin of a frame whose count is zero answers with status 4 (error) and changes nothing.
- R10: req_ready stays 0 from the acceptance of a missing pin until its response. A request held meanwhile is taken only afterwards and sees the updated pool.
- R11: A pin of a resident page whose count is already at the maximum answers with status 4 (error) and leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Command present |
| req_ready | output | 1 | Command accepted when high with req_valid |
| req_unpin | input | 1 | 0 = pin, 1 = unpin |
| req_page | input | PAGE_W | Page id for pin |
| req_frame | input | IDX_W | Frame number for unpin |
| req_modified | input | 1 | Unpin: holder changed the frame |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_status | output | 3 | 0 hit, 1 filled, 2 done, 3 busy, 4 error |
| rsp_frame | output | IDX_W | Frame the response refers to |
| st_req | output | 1 | Store transfer request, held until acknowledged |
| st_write | output | 1 | 1 = write frame out, 0 = read page in |
| st_page | output | PAGE_W | Page id of the transfer |
| st_frame | output | IDX_W | Frame of the transfer |
| st_ack | input | 1 | Store finished the transfer (one cycle) |

## Verification
The overlap to provoke is the completion of a refill and the arrival of a new command. The bench keeps a second pin of the same page asserted on the request port during a miss. It checks that req_ready stays low through the write-back and read. It then checks that the held command is taken only in the cycle after the fill response, and that it gets a hit on the freshly loaded frame with the count raised to two. The ready-low window is judged cycle by cycle. The pool contents are judged through a bench-side model of every frame.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  typedef enum logic [2:0] {
    ST_HIT  = 3'd0,
    ST_FILL = 3'd1,
    ST_DONE = 3'd2,
    ST_BUSY = 3'd3,
    ST_ERR  = 3'd4
  } fpm_status_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_WB   = 2'd1,
    S_FILL = 2'd2
  } fpm_state_e;
endpackage

// File: rtl/fpm_slot.sv
module fpm_slot #(
  parameter int PAGE_W = 16,
  parameter int PIN_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld,
  input  logic [PAGE_W-1:0] ld_page,
  input  logic              inc,
  input  logic              dec,
  input  logic              mark,
  input  logic              clean,
  output logic              valid,
  output logic [PAGE_W-1:0] page,
  output logic [PIN_W-1:0]  pin,
  output logic              dirty
);
  localparam logic [PIN_W-1:0] PIN_MAX = {PIN_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      page  <= '0;
      pin   <= '0;
      dirty <= 1'b0;
    end else if (ld) begin
      valid <= 1'b1;
      page  <= ld_page;
      pin   <= PIN_W'(1);
      dirty <= 1'b0;
    end else begin
      if (inc)      pin <= pin + 1'b1;
      else if (dec) pin <= pin - 1'b1;
      if (clean)     dirty <= 1'b0;
      else if (mark) dirty <= 1'b1;
    end
  end

  // R9: a decrement is never issued against an empty count
  a_r9_no_underflow: assert property (@(posedge clk) disable iff (rst)
    dec |-> pin != '0);
  // R11: an increment is never issued against a saturated count
  a_r11_no_wrap: assert property (@(posedge clk) disable iff (rst)
    inc |-> pin != PIN_MAX);
  // R6: a cleaned frame is dirty no more on the next cycle
  a_r6_clean_takes: assert property (@(posedge clk) disable iff (rst)
    clean && !ld |=> !dirty);
endmodule

// File: rtl/fpm_lookup.sv
module fpm_lookup #(
  parameter int N_FRAMES = 8,
  parameter int PAGE_W   = 16,
  parameter int IDX_W    = 3
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [N_FRAMES-1:0]            valid,
  input  logic [N_FRAMES-1:0][PAGE_W-1:0] pages,
  input  logic [PAGE_W-1:0]              key,
  output logic                           hit,
  output logic [IDX_W-1:0]               idx
);
  logic [N_FRAMES-1:0] match;

  genvar g;
  generate
    for (g = 0; g < N_FRAMES; g++) begin : g_cmp
      assign match[g] = valid[g] && (pages[g] == key);
    end
  endgenerate

  always_comb begin
    idx = '0;
    for (int i = N_FRAMES - 1; i >= 0; i--) begin
      if (match[i]) idx = IDX_W'(i);
    end
  end

  assign hit = |match;

  // R2: a page never sits in two frames at once
  a_r2_unique_page: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match));
endmodule

// File: rtl/fpm_victim.sv
module fpm_victim #(
  parameter int N_FRAMES = 8,
  parameter int PIN_W    = 4,
  parameter int IDX_W    = 3
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [N_FRAMES-1:0][PIN_W-1:0] pins,
  output logic                           found,
  output logic [IDX_W-1:0]               idx
);
  logic [N_FRAMES-1:0] free_vec;

  genvar g;
  generate
    for (g = 0; g < N_FRAMES; g++) begin : g_free
      assign free_vec[g] = (pins[g] == '0);
    end
  endgenerate

  always_comb begin
    idx = '0;
    for (int i = N_FRAMES - 1; i >= 0; i--) begin
      if (free_vec[i]) idx = IDX_W'(i);
    end
  end

  assign found = |free_vec;

  // R3: the nominated frame carries no pins
  a_r3_victim_unpinned: assert property (@(posedge clk) disable iff (rst)
    found |-> pins[idx] == '0);
endmodule

// File: rtl/frame_pool_mgr.sv
module frame_pool_mgr
  import fpm_pkg::*;
#(
  parameter int N_FRAMES = 8,
  parameter int PAGE_W   = 16,
  parameter int PIN_W    = 4,
  parameter int IDX_W    = (N_FRAMES > 1) ? $clog2(N_FRAMES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_unpin,
  input  logic [PAGE_W-1:0] req_page,
  input  logic [IDX_W-1:0]  req_frame,
  input  logic              req_modified,
  output logic              rsp_valid,
  output logic [2:0]        rsp_status,
  output logic [IDX_W-1:0]  rsp_frame,
  output logic              st_req,
  output logic              st_write,
  output logic [PAGE_W-1:0] st_page,
  output logic [IDX_W-1:0]  st_frame,
  input  logic              st_ack
);
  localparam logic [PIN_W-1:0] PIN_MAX = {PIN_W{1'b1}};

  fpm_state_e  state;
  fpm_status_e rsp_q;
  logic [IDX_W-1:0]  vic_q;
  logic [PAGE_W-1:0] page_q;

  logic [N_FRAMES-1:0]             s_valid;
  logic [N_FRAMES-1:0]             s_dirty;
  logic [N_FRAMES-1:0][PAGE_W-1:0] s_page;
  logic [N_FRAMES-1:0][PIN_W-1:0]  s_pin;
  logic [N_FRAMES-1:0]             c_ld, c_inc, c_dec, c_mark, c_clean;

  logic             hit;
  logic [IDX_W-1:0] hit_idx;
  logic             v_found;
  logic [IDX_W-1:0] v_idx;

  logic accept, pin_acc, unpin_acc, hit_full, frame_ok, unpin_ok;

  fpm_lookup #(.N_FRAMES(N_FRAMES), .PAGE_W(PAGE_W), .IDX_W(IDX_W)) u_lookup (
    .clk(clk), .rst(rst), .valid(s_valid), .pages(s_page), .key(req_page),
    .hit(hit), .idx(hit_idx)
  );

  fpm_victim #(.N_FRAMES(N_FRAMES), .PIN_W(PIN_W), .IDX_W(IDX_W)) u_victim (
    .clk(clk), .rst(rst), .pins(s_pin), .found(v_found), .idx(v_idx)
  );

  assign req_ready = (state == S_IDLE);
  assign accept    = req_valid && req_ready;
  assign pin_acc   = accept && !req_unpin;
  assign unpin_acc = accept && req_unpin;
  assign hit_full  = (s_pin[hit_idx] == PIN_MAX);
  assign frame_ok  = ({1'b0, req_frame} < (IDX_W + 1)'(N_FRAMES));
  assign unpin_ok  = frame_ok && s_valid[req_frame] && (s_pin[req_frame] != '0);

  genvar g;
  generate
    for (g = 0; g < N_FRAMES; g++) begin : g_slot
      assign c_ld[g]    = (state == S_FILL) && st_ack && (vic_q == IDX_W'(g));
      assign c_clean[g] = (state == S_WB) && st_ack && (vic_q == IDX_W'(g));
      assign c_inc[g]   = pin_acc && hit && !hit_full && (hit_idx == IDX_W'(g));
      assign c_dec[g]   = unpin_acc && unpin_ok && (req_frame == IDX_W'(g));
      assign c_mark[g]  = c_dec[g] && req_modified;

      fpm_slot #(.PAGE_W(PAGE_W), .PIN_W(PIN_W)) u_slot (
        .clk(clk), .rst(rst),
        .ld(c_ld[g]), .ld_page(page_q),
        .inc(c_inc[g]), .dec(c_dec[g]), .mark(c_mark[g]), .clean(c_clean[g]),
        .valid(s_valid[g]), .page(s_page[g]), .pin(s_pin[g]), .dirty(s_dirty[g])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      rsp_valid <= 1'b0;
      rsp_q     <= ST_HIT;
      rsp_frame <= '0;
      vic_q     <= '0;
      page_q    <= '0;
      st_req    <= 1'b0;
      st_write  <= 1'b0;
      st_page   <= '0;
      st_frame  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (unpin_acc) begin
            rsp_valid <= 1'b1;
            rsp_frame <= req_frame;
            rsp_q     <= unpin_ok ? ST_DONE : ST_ERR;
          end else if (pin_acc) begin
            if (hit) begin
              rsp_valid <= 1'b1;
              rsp_frame <= hit_idx;
              rsp_q     <= hit_full ? ST_ERR : ST_HIT;
            end else if (v_found) begin
              vic_q    <= v_idx;
              page_q   <= req_page;
              st_req   <= 1'b1;
              st_frame <= v_idx;
              if (s_valid[v_idx] && s_dirty[v_idx]) begin
                st_write <= 1'b1;
                st_page  <= s_page[v_idx];
                state    <= S_WB;
              end else begin
                st_write <= 1'b0;
                st_page  <= req_page;
                state    <= S_FILL;
              end
            end else begin
              rsp_valid <= 1'b1;
              rsp_frame <= '0;
              rsp_q     <= ST_BUSY;
            end
          end
        end
        S_WB: begin
          if (st_ack) begin
            st_write <= 1'b0;
            st_page  <= page_q;
            state    <= S_FILL;
          end
        end
        S_FILL: begin
          if (st_ack) begin
            st_req    <= 1'b0;
            rsp_valid <= 1'b1;
            rsp_frame <= vic_q;
            rsp_q     <= ST_FILL;
            state     <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign rsp_status = rsp_q;

  // R4: a write-back is held steady until the store acknowledges it
  a_r4_write_held: assert property (@(posedge clk) disable iff (rst)
    st_req && st_write && !st_ack |=> st_req && st_write && $stable(st_page));
  // R4: an acknowledged write-back is followed by a read of the same frame
  a_r4_read_follows: assert property (@(posedge clk) disable iff (rst)
    st_req && st_write && st_ack |=> st_req && !st_write && $stable(st_frame));
  // R10: no command is taken while the store is busy
  a_r10_ready_low: assert property (@(posedge clk) disable iff (rst)
    st_req |-> !req_ready);
  // R7: a busy answer never coincides with store traffic
  a_r7_busy_quiet: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_status == 3'd3 |-> !st_req);
  // R5: a filled frame is pinned exactly once and clean
  a_r5_fill_state: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_status == 3'd1 |-> s_pin[rsp_frame] == PIN_W'(1) && !s_dirty[rsp_frame]);
endmodule

// File: tb/frame_pool_mgr_test.sv
module frame_pool_mgr_test;
  localparam int NF = 4;
  localparam int PW = 8;
  localparam int CW = 2;
  localparam int IW = 2;
  localparam int PMAX = 3;
  localparam int LAT = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_unpin = 1'b0, req_modified = 1'b0;
  logic [PW-1:0] req_page = '0;
  logic [IW-1:0] req_frame = '0;
  logic req_ready, rsp_valid, st_req, st_write;
  logic [2:0] rsp_status;
  logic [IW-1:0] rsp_frame, st_frame;
  logic [PW-1:0] st_page;
  logic st_ack = 1'b0;

  always #10 clk = ~clk;

  frame_pool_mgr #(.N_FRAMES(NF), .PAGE_W(PW), .PIN_W(CW)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_unpin(req_unpin), .req_page(req_page), .req_frame(req_frame),
    .req_modified(req_modified), .rsp_valid(rsp_valid), .rsp_status(rsp_status),
    .rsp_frame(rsp_frame), .st_req(st_req), .st_write(st_write),
    .st_page(st_page), .st_frame(st_frame), .st_ack(st_ack)
  );

  int n_cmp = 0;
  int n_bad = 0;

  // store model: acknowledges each request after LAT cycles and logs it
  int cnt = 0;
  int lg_n = 0;
  bit lg_w [0:1023];
  int lg_pg [0:1023];
  int lg_fr [0:1023];

  always @(negedge clk) begin
    if (rst) begin
      st_ack = 1'b0;
      cnt = 0;
    end else if (st_ack) begin
      st_ack = 1'b0;
      cnt = 0;
    end else if (st_req) begin
      if (cnt == LAT) begin
        st_ack = 1'b1;
        lg_w[lg_n % 1024] = st_write;
        lg_pg[lg_n % 1024] = int'(st_page);
        lg_fr[lg_n % 1024] = int'(st_frame);
        lg_n++;
      end else cnt++;
    end
  end

  // model of the pool
  bit m_v [NF];
  int m_pg [NF];
  int m_pin [NF];
  bit m_d [NF];
  int e_st, e_fr, e_nlog, e_wpg;
  bit e_wb;

  task automatic chk(string tag, int got, int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic void predict(bit un, int pg, int fr, bit md);
    int h, v;
    e_nlog = 0; e_wb = 0; e_fr = 0; e_wpg = 0;
    if (un) begin
      e_fr = fr;
      if (!m_v[fr] || m_pin[fr] == 0) e_st = 4;
      else begin
        e_st = 2; m_pin[fr]--; if (md) m_d[fr] = 1;
      end
    end else begin
      h = -1; v = -1;
      for (int i = NF - 1; i >= 0; i--) if (m_v[i] && m_pg[i] == pg) h = i;
      for (int i = NF - 1; i >= 0; i--) if (m_pin[i] == 0) v = i;
      if (h >= 0) begin
        e_fr = h;
        if (m_pin[h] == PMAX) e_st = 4;
        else begin e_st = 0; m_pin[h]++; end
      end else if (v < 0) e_st = 3;
      else begin
        e_st = 1; e_fr = v;
        if (m_v[v] && m_d[v]) begin e_wb = 1; e_wpg = m_pg[v]; e_nlog = 2; end
        else e_nlog = 1;
        m_v[v] = 1; m_pg[v] = pg; m_pin[v] = 1; m_d[v] = 0;
      end
    end
  endfunction

  function automatic string tag_of(int st);
    case (st)
      0: return "R2 hit";
      1: return "R5 fill";
      2: return "R8 unpin";
      3: return "R7 busy";
      default: return "R9/R11 error";
    endcase
  endfunction

  task automatic judge(int lg0, int waitc, bit saw_ready);
    chk({tag_of(e_st), " status"}, int'(rsp_status), e_st);
    if (e_st <= 2) chk("R3 frame", int'(rsp_frame), e_fr);
    if (e_st == 0) chk("R2 latency", waitc, 0);
    if (e_st == 1) chk("R10 ready low during miss", int'(saw_ready), 0);
    chk("R4 R7 store request count", lg_n - lg0, e_nlog);
    if (e_nlog == 2 && lg_n - lg0 == 2) begin
      chk("R4 write first", int'(lg_w[lg0 % 1024]), 1);
      chk("R4 old page out", lg_pg[lg0 % 1024], e_wpg);
      chk("R4 write frame", lg_fr[lg0 % 1024], e_fr);
    end
    if (e_nlog >= 1 && lg_n - lg0 == e_nlog) begin
      chk("R6 read entry", int'(lg_w[(lg_n - 1) % 1024]), 0);
      chk("R5 read frame", lg_fr[(lg_n - 1) % 1024], e_fr);
    end
  endtask

  task automatic run_op(bit un, int pg, int fr, bit md);
    int lg0, waitc;
    bit saw;
    predict(un, pg, fr, md);
    lg0 = lg_n;
    @(negedge clk);
    req_valid = 1'b1; req_unpin = un; req_page = PW'(pg);
    req_frame = IW'(fr); req_modified = md;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    waitc = 0; saw = 0;
    while (!rsp_valid && waitc < 100) begin
      if (req_ready) saw = 1;
      @(negedge clk);
      waitc++;
    end
    judge(lg0, waitc, saw);
  endtask

  // R10: a second pin is held on the port while a miss is serviced
  task automatic run_pair(int pg);
    int lg0, waitc, s1, f1, n1;
    bit saw;
    predict(0, pg, 0, 0);
    s1 = e_st; f1 = e_fr; n1 = e_nlog;
    lg0 = lg_n;
    @(negedge clk);
    req_valid = 1'b1; req_unpin = 1'b0; req_page = PW'(pg);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    predict(0, pg, 0, 0);
    waitc = 0; saw = 0;
    while (!rsp_valid && waitc < 100) begin
      if (req_ready) saw = 1;
      @(negedge clk);
      waitc++;
    end
    chk("R10 first status", int'(rsp_status), s1);
    chk("R10 first frame", int'(rsp_frame), f1);
    chk("R10 held request not taken early", int'(saw), 0);
    chk("R10 store count", lg_n - lg0, n1);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 held request answered", int'(rsp_valid), 1);
    chk("R10 held request sees fill", int'(rsp_status), e_st);
    chk("R10 held request frame", int'(rsp_frame), e_fr);
  endtask

  bit done = 0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    for (int i = 0; i < NF; i++) begin m_v[i] = 0; m_pg[i] = 0; m_pin[i] = 0; m_d[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ready", int'(req_ready), 1);
    chk("R1 rsp_valid", int'(rsp_valid), 0);
    chk("R1 st_req", int'(st_req), 0);

    for (int p = 10; p < 14; p++) run_op(0, p, 0, 0);  // R5 fills of empty frames
    run_op(0, 10, 0, 0);                                // R2
    run_op(0, 10, 0, 0);                                // R2 up to max
    run_op(0, 10, 0, 0);                                // R11 saturated
    run_op(0, 14, 0, 0);                                // R7 all pinned
    run_op(1, 0, 1, 1);                                 // R8 with modified
    run_op(1, 0, 1, 0);                                 // R9 empty count
    run_op(0, 14, 0, 0);                                // R4 dirty victim
    run_op(1, 0, 2, 0);                                 // R8 clean
    run_pair(20);                                       // R10 collision
    run_op(1, 0, 2, 0);
    run_op(1, 0, 2, 1);                                 // R6 mark then replace
    run_op(0, 21, 0, 0);

    seed = 32'h1234;
    for (int k = 0; k < 600; k++) begin
      bit un, md;
      int pg, fr;
      seed = seed * 32'd1103515245 + 32'd12345;
      un = seed[20] ^ seed[27];
      md = seed[18];
      pg = 30 + int'(seed[25:23] % 3'd6);
      fr = int'(seed[17:16]);
      run_op(un, pg, fr, md);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule